// File: doc/BRIEF.md
# Two-Thread Decode Stage Controller

This block is the decode stage of a pipeline that runs two hardware threads. Each cycle it takes up to `W` instruction slots from fetch. Each slot carries a thread tag. The block hands up to `W` instructions on to rename. Each thread has its own six-state status machine and its own skid buffer. When a thread is stalled, the instructions that arrive for it are held in its skid buffer rather than lost.

A thread is held back by stall requests from three later stages: rename, execute and commit. Commit can also order a squash. Decode checks every PC-relative branch it sends by comparing the predicted target with the target that comes with the slot. On a mismatch it drops the younger work of that thread and sends a redirect to fetch. Block and unblock pulses tell fetch when a thread stops or resumes. An activity flag lets the surrounding core see whether the stage has anything to do.

Top module: `dec_stage`

## Requirements
- R1: A thread is stalled when any of its rename, execute or commit stall inputs is high. While it is stalled, no output slot carries it, and its fetch slots are appended to its skid buffer. The skid buffer holds 2*W entries. The thread then enters Blocked.
- R2: `blk_o[t]` is a one-cycle pulse. It is high in the cycle after thread t enters Blocked from any other state, and it is never high in two consecutive cycles.
- R3: Blocked always moves to Unblocking when the stall is gone. While a thread is Unblocking, its skid entries go out oldest first, before any fetch slot of the same cycle for that thread.
- R4: `unblk_o[t]` pulses for one cycle after thread t goes from Unblocking to Running. This happens when the thread's skid buffer and its fetch slots have all been sent.
- R5: A commit squash of thread t does four things. It drops t's fetch slots that cycle. It empties t's skid buffer. It keeps t off the outputs. It keeps `blk_o[t]` and `unblk_o[t]` low in the next cycle.
- R6: A branch slot (`fetch_br_i` = 1) whose predicted target differs from its computed target is mispredicted. When thread t sends such a slot, later instructions of t are dropped that cycle: its remaining skid entries and its fetch slots. `redir_vld_o[t]` rises in the same cycle, with `redir_pc_o` set to the computed target. Fetch slots for t are dropped in the following cycle.
- R7: A commit squash of thread t overrides a branch squash of t in the same cycle, so `redir_vld_o[t]` stays low.
- R8: Valid output slots are packed from slot 0 and number at most W. The thread that has priority fills its slots first, and the other thread takes the slots left over. Priority alternates every cycle, with thread 0 first after reset. Instructions not granted a slot stay in the skid buffer, and the thread is then Unblocking.
- R9: `active_o` is low only when no fetch slot is valid, both skid buffers are empty and both threads are Idle.
- R10: During reset, no output slot, redirect, block or unblock pulse is asserted, and `active_o` is low while no fetch slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_vld_i | input | W | Fetch slot valid |
| fetch_tid_i | input | W | Thread tag per fetch slot |
| fetch_data_i | input | W*DW | Instruction word per slot |
| fetch_br_i | input | W | Slot is a PC-relative branch |
| fetch_pred_i | input | W*AW | Predicted target per slot |
| fetch_tgt_i | input | W*AW | Computed target per slot |
| ren_stall_i | input | 2 | Rename stall per thread |
| exe_stall_i | input | 2 | Execute stall per thread |
| cmt_stall_i | input | 2 | Commit stall per thread |
| cmt_squash_i | input | 2 | Commit squash per thread |
| out_vld_o | output | W | Output slot valid |
| out_tid_o | output | W | Thread tag per output slot |
| out_data_o | output | W*DW | Instruction word per output slot |
| redir_vld_o | output | 2 | Branch redirect to fetch, per thread |
| redir_pc_o | output | 2*AW | Corrected PC per thread |
| blk_o | output | 2 | Block pulse toward fetch |
| unblk_o | output | 2 | Unblock pulse toward fetch |
| active_o | output | 1 | Stage has work |

## Verification
The hardest case to reach is a mispredicted branch that sits inside a partly drained skid buffer. It has to show up while the other thread holds slot priority, so that only part of the buffer can leave in that cycle. Getting there takes stall bursts on one thread while fetch keeps feeding both threads. The stall then has to lift at the right point in the round-robin turn. The stimulus runs three phases: free flow, random three-source stall bursts, and then bursts mixed with commit squashes and dense mispredicted branches. A queue-based model rebuilds every output each cycle, so these overlaps are checked whenever they occur.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int NTHR = 2;
  localparam int DW   = 32;
  localparam int AW   = 32;

  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE, ST_SSQ, ST_SQ, ST_BLK, ST_UNB
  } tstate_e;

  typedef struct packed {
    logic          br;
    logic [AW-1:0] pred;
    logic [AW-1:0] tgt;
    logic [DW-1:0] data;
  } slot_t;
endpackage

// File: rtl/dec_thread.sv
module dec_thread
  import dec_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int TID   = 0,
  parameter int LEN   = DEPTH + W,
  parameter int CW    = $clog2(LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  fetch_vld_i,
  input  logic [W-1:0]  fetch_tid_i,
  input  slot_t         fetch_ent_i [W],
  input  logic          stall_i,
  input  logic          squash_i,
  input  logic [CW-1:0] grant_i,
  output logic [CW-1:0] avail_o,
  output logic [DW-1:0] sdata_o [W],
  output logic          redir_vld_o,
  output logic [AW-1:0] redir_pc_o,
  output logic          blk_o,
  output logic          unblk_o,
  output logic          busy_o
);
  tstate_e       st_q, st_d;
  slot_t         skid_q [DEPTH];
  slot_t         skid_d [DEPTH];
  slot_t         strm   [LEN];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rank   [W];
  logic [CW-1:0] nf, len, fmis, sh, keep;
  logic          hmis, can_send, mis_act;
  logic          blk_q, unblk_q;

  // per-thread stream: skid (oldest first) then own fetch slots in slot order
  always_comb begin
    nf = '0;
    for (int k = 0; k < W; k++) begin
      rank[k] = nf;
      if (fetch_vld_i[k] && fetch_tid_i[k] == 1'(TID)) nf = nf + 1'b1;
    end
    len = cnt_q + nf;
    for (int i = 0; i < LEN; i++) strm[i] = '0;
    for (int i = 0; i < DEPTH; i++)
      if (i < int'(cnt_q)) strm[i] = skid_q[i];
    for (int k = 0; k < W; k++)
      if (fetch_vld_i[k] && fetch_tid_i[k] == 1'(TID))
        strm[cnt_q + rank[k]] = fetch_ent_i[k];
  end

  always_comb begin
    hmis = 1'b0;
    fmis = '0;
    for (int i = 0; i < LEN; i++)
      if (!hmis && i < int'(len) && strm[i].br && strm[i].pred != strm[i].tgt) begin
        hmis = 1'b1;
        fmis = CW'(i);
      end
  end

  assign can_send = !squash_i && !stall_i &&
                    (st_q == ST_RUN || st_q == ST_IDLE || st_q == ST_UNB);
  assign avail_o  = !can_send ? '0 : (hmis ? fmis + 1'b1 : len);
  assign mis_act  = can_send && hmis && (fmis < grant_i);

  assign redir_vld_o = mis_act;
  assign redir_pc_o  = strm[fmis].tgt;

  for (genvar s = 0; s < W; s++) begin : g_sd
    assign sdata_o[s] = strm[s].data;
  end

  always_comb begin
    st_d = st_q;
    sh   = '0;
    keep = '0;
    if (squash_i) begin
      st_d = ST_SQ;
    end else if (st_q == ST_SSQ || st_q == ST_SQ) begin
      st_d = stall_i ? ST_BLK : ST_IDLE;
    end else if (stall_i || st_q == ST_BLK) begin
      st_d = stall_i ? ST_BLK : ST_UNB;
      keep = (len > CW'(DEPTH)) ? CW'(DEPTH) : len;
    end else if (mis_act) begin
      st_d = ST_SSQ;
    end else begin
      sh   = grant_i;
      keep = ((len - grant_i) > CW'(DEPTH)) ? CW'(DEPTH) : len - grant_i;
      if (keep != '0)          st_d = ST_UNB;
      else if (st_q == ST_UNB) st_d = ST_RUN;
      else                     st_d = (grant_i != '0) ? ST_RUN : ST_IDLE;
    end
    cnt_d = keep;
    for (int j = 0; j < DEPTH; j++) begin
      skid_d[j] = '0;
      if (j < int'(keep) && (j + int'(sh)) < LEN) skid_d[j] = strm[j + int'(sh)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      blk_q   <= 1'b0;
      unblk_q <= 1'b0;
      for (int j = 0; j < DEPTH; j++) skid_q[j] <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      blk_q   <= (st_d == ST_BLK) && (st_q != ST_BLK);
      unblk_q <= (st_q == ST_UNB) && (st_d == ST_RUN);
      for (int j = 0; j < DEPTH; j++) skid_q[j] <= skid_d[j];
    end
  end

  assign blk_o   = blk_q;
  assign unblk_o = unblk_q;
  assign busy_o  = (st_q != ST_IDLE) || (cnt_q != '0);
endmodule

// File: rtl/dec_slot_arb.sv
module dec_slot_arb
  import dec_pkg::*;
#(
  parameter int W  = 4,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] avail_i [NTHR],
  input  logic [DW-1:0] sdata_i [NTHR][W],
  output logic [CW-1:0] grant_o [NTHR],
  output logic [W-1:0]  out_vld_o,
  output logic [W-1:0]  out_tid_o,
  output logic [DW-1:0] out_data_o [W]
);
  logic          rr_q;
  logic          p, o;
  logic [CW-1:0] gp, go, room;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= 1'b0;
    else         rr_q <= ~rr_q;
  end

  assign p = rr_q;
  assign o = ~rr_q;

  always_comb begin
    gp   = (avail_i[p] > CW'(W)) ? CW'(W) : avail_i[p];
    room = CW'(W) - gp;
    go   = (avail_i[o] > room) ? room : avail_i[o];
    for (int t = 0; t < NTHR; t++) grant_o[t] = (t == int'(p)) ? gp : go;
    for (int s = 0; s < W; s++) begin
      out_vld_o[s]  = 1'b0;
      out_tid_o[s]  = 1'b0;
      out_data_o[s] = '0;
      if (s < int'(gp)) begin
        out_vld_o[s]  = 1'b1;
        out_tid_o[s]  = p;
        out_data_o[s] = sdata_i[p][s];
      end else if ((s - int'(gp)) < int'(go)) begin
        out_vld_o[s]  = 1'b1;
        out_tid_o[s]  = o;
        out_data_o[s] = sdata_i[o][s - int'(gp)];
      end
    end
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 2 * W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         fetch_vld_i,
  input  logic [W-1:0]         fetch_tid_i,
  input  logic [W*DW-1:0]      fetch_data_i,
  input  logic [W-1:0]         fetch_br_i,
  input  logic [W*AW-1:0]      fetch_pred_i,
  input  logic [W*AW-1:0]      fetch_tgt_i,
  input  logic [NTHR-1:0]      ren_stall_i,
  input  logic [NTHR-1:0]      exe_stall_i,
  input  logic [NTHR-1:0]      cmt_stall_i,
  input  logic [NTHR-1:0]      cmt_squash_i,
  output logic [W-1:0]         out_vld_o,
  output logic [W-1:0]         out_tid_o,
  output logic [W*DW-1:0]      out_data_o,
  output logic [NTHR-1:0]      redir_vld_o,
  output logic [NTHR*AW-1:0]   redir_pc_o,
  output logic [NTHR-1:0]      blk_o,
  output logic [NTHR-1:0]      unblk_o,
  output logic                 active_o
);
  localparam int LEN = DEPTH + W;
  localparam int CW  = $clog2(LEN + 1);

  slot_t           fent  [W];
  logic [NTHR-1:0] thr_stall;
  logic [NTHR-1:0] busy;
  logic [CW-1:0]   avail [NTHR];
  logic [CW-1:0]   grant [NTHR];
  logic [DW-1:0]   sdata [NTHR][W];
  logic [DW-1:0]   odata [W];

  always_comb
    for (int k = 0; k < W; k++) begin
      fent[k].br   = fetch_br_i[k];
      fent[k].pred = fetch_pred_i[k*AW +: AW];
      fent[k].tgt  = fetch_tgt_i[k*AW +: AW];
      fent[k].data = fetch_data_i[k*DW +: DW];
    end

  assign thr_stall = ren_stall_i | exe_stall_i | cmt_stall_i;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    dec_thread #(.W(W), .DEPTH(DEPTH), .TID(t), .LEN(LEN), .CW(CW)) u_thr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fetch_vld_i (fetch_vld_i),
      .fetch_tid_i (fetch_tid_i),
      .fetch_ent_i (fent),
      .stall_i     (thr_stall[t]),
      .squash_i    (cmt_squash_i[t]),
      .grant_i     (grant[t]),
      .avail_o     (avail[t]),
      .sdata_o     (sdata[t]),
      .redir_vld_o (redir_vld_o[t]),
      .redir_pc_o  (redir_pc_o[t*AW +: AW]),
      .blk_o       (blk_o[t]),
      .unblk_o     (unblk_o[t]),
      .busy_o      (busy[t])
    );
  end

  dec_slot_arb #(.W(W), .CW(CW)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .avail_i    (avail),
    .sdata_i    (sdata),
    .grant_o    (grant),
    .out_vld_o  (out_vld_o),
    .out_tid_o  (out_tid_o),
    .out_data_o (odata)
  );

  always_comb
    for (int s = 0; s < W; s++) out_data_o[s*DW +: DW] = odata[s];

  assign active_o = (|fetch_vld_i) || (|busy);
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk #(
  parameter int W    = 4,
  parameter int NTHR = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [W-1:0]    out_vld_o,
  input logic [W-1:0]    out_tid_o,
  input logic [NTHR-1:0] stall_i,
  input logic [NTHR-1:0] cmt_squash_i,
  input logic [NTHR-1:0] redir_vld_o,
  input logic [NTHR-1:0] blk_o,
  input logic [NTHR-1:0] unblk_o,
  input logic            active_o
);
  logic [NTHR-1:0] sent;

  always_comb begin
    sent = '0;
    for (int s = 0; s < W; s++)
      if (out_vld_o[s]) sent[out_tid_o[s]] = 1'b1;
  end

  // R8
  packed_slots_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o & (out_vld_o + W'(1))) == '0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> out_vld_o == '0);

  for (genvar t = 0; t < NTHR; t++) begin : g_t
    // R1
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i[t] |-> !sent[t]);
    // R2
    blk_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_o[t] |=> !blk_o[t]);
    // R5
    squash_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmt_squash_i[t] |=> !blk_o[t] && !unblk_o[t]);
    // R5
    squash_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmt_squash_i[t] |-> !sent[t]);
    // R7
    squash_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmt_squash_i[t] |-> !redir_vld_o[t]);
  end
endmodule

bind dec_stage dec_stage_chk #(.W(W), .NTHR(dec_pkg::NTHR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .out_vld_o    (out_vld_o),
  .out_tid_o    (out_tid_o),
  .stall_i      (thr_stall),
  .cmt_squash_i (cmt_squash_i),
  .redir_vld_o  (redir_vld_o),
  .blk_o        (blk_o),
  .unblk_o      (unblk_o),
  .active_o     (active_o)
);

// File: tb/sim_dec_stage.sv
`timescale 1ns/1ps
module sim_dec_stage;
  localparam int W = 4;
  localparam int DEPTH = 2 * W;
  localparam int NCYC = 3000;
  localparam int S_RUN = 0, S_IDLE = 1, S_SSQ = 2, S_SQ = 3, S_BLK = 4, S_UNB = 5;

  typedef struct {
    logic [31:0] data;
    bit          br;
    logic [31:0] pred;
    logic [31:0] tgt;
  } bslot_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] fv = '0, ft = '0, fb = '0;
  logic [W*32-1:0] fd = '0, fp = '0, fg = '0;
  logic [1:0] rs = '0, es = '0, cs = '0, sq = '0;
  logic [W-1:0] out_vld_o, out_tid_o;
  logic [W*32-1:0] out_data_o;
  logic [1:0] redir_vld_o, blk_o, unblk_o;
  logic [63:0] redir_pc_o;
  logic active_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bslot_t skid [2][$];
  int st [2];
  bit eblk [2], eunb [2];
  int rr = 0;
  int stall_left [2];

  always #5 clk_i = ~clk_i;

  dec_stage #(.W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .fetch_vld_i(fv), .fetch_tid_i(ft),
    .fetch_data_i(fd), .fetch_br_i(fb), .fetch_pred_i(fp), .fetch_tgt_i(fg),
    .ren_stall_i(rs), .exe_stall_i(es), .cmt_stall_i(cs), .cmt_squash_i(sq),
    .out_vld_o(out_vld_o), .out_tid_o(out_tid_o), .out_data_o(out_data_o),
    .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o), .blk_o(blk_o),
    .unblk_o(unblk_o), .active_o(active_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int ph);
    int k_t [2];
    k_t[0] = skid[0].size();
    k_t[1] = skid[1].size();
    rs = '0; es = '0; cs = '0; sq = '0;
    for (int t = 0; t < 2; t++) begin
      if (ph >= 1 && stall_left[t] == 0 && $urandom_range(0, 9) == 0)
        stall_left[t] = $urandom_range(1, 6);
      if (stall_left[t] > 0) begin
        case ($urandom_range(0, 2))
          0: rs[t] = 1'b1;
          1: es[t] = 1'b1;
          default: cs[t] = 1'b1;
        endcase
        stall_left[t]--;
      end
      if (ph >= 2 && $urandom_range(0, 19) == 0) sq[t] = 1'b1;
    end
    for (int k = 0; k < W; k++) begin
      logic [31:0] tg;
      int t;
      t = $urandom_range(0, 1);
      tg = $urandom;
      ft[k] = t[0];
      fv[k] = ($urandom_range(0, 3) != 0);
      if (fv[k]) begin
        if (k_t[t] + 1 > DEPTH) fv[k] = 1'b0;
        else k_t[t]++;
      end
      fd[k*32 +: 32] = $urandom;
      fb[k] = ($urandom_range(0, (ph >= 2) ? 3 : 6) == 0);
      fg[k*32 +: 32] = tg;
      fp[k*32 +: 32] = ($urandom_range(0, 1) == 0) ? tg : (tg ^ 32'h4);
    end
  endtask

  task automatic model_check();
    bslot_t str [2][$];
    int fm [2], av [2], g [2];
    bit cs_ok [2], stl [2], mact [2];
    bit ev [W]; bit et [W]; logic [31:0] ed [W];
    int p, o, room, ns;
    string tag;
    for (int t = 0; t < 2; t++) begin
      str[t] = skid[t];
      for (int k = 0; k < W; k++)
        if (fv[k] && ft[k] == t[0]) begin
          bslot_t e;
          e.data = fd[k*32 +: 32]; e.br = fb[k];
          e.pred = fp[k*32 +: 32]; e.tgt = fg[k*32 +: 32];
          str[t].push_back(e);
        end
      stl[t] = rs[t] | es[t] | cs[t];
      cs_ok[t] = !sq[t] && !stl[t] && (st[t] == S_RUN || st[t] == S_IDLE || st[t] == S_UNB);
      fm[t] = -1;
      foreach (str[t][i])
        if (fm[t] < 0 && str[t][i].br && str[t][i].pred != str[t][i].tgt) fm[t] = i;
      av[t] = !cs_ok[t] ? 0 : (fm[t] >= 0 ? fm[t] + 1 : str[t].size());
    end
    p = rr; o = 1 - rr;
    g[p] = (av[p] > W) ? W : av[p];
    room = W - g[p];
    g[o] = (av[o] > room) ? room : av[o];
    for (int s = 0; s < W; s++) begin
      ev[s] = 0; et[s] = 0; ed[s] = '0;
      if (s < g[p]) begin ev[s] = 1; et[s] = p[0]; ed[s] = str[p][s].data; end
      else if (s - g[p] < g[o]) begin ev[s] = 1; et[s] = o[0]; ed[s] = str[o][s - g[p]].data; end
    end
    if (sq != 0) tag = "R5";
    else if (stl[0] || stl[1]) tag = "R1";
    else if (st[0] == S_UNB || st[1] == S_UNB) tag = "R3";
    else tag = "R8";
    for (int s = 0; s < W; s++) begin
      bit ok;
      ok = (out_vld_o[s] == ev[s]) &&
           (!ev[s] || (out_tid_o[s] == et[s] && out_data_o[s*32 +: 32] == ed[s]));
      chk(ok, tag, $sformatf("slot%0d vld/tid/data", s),
          {31'b0, out_vld_o[s], out_tid_o[s], out_data_o[s*32 +: 31]},
          {31'b0, ev[s], et[s], ed[s][30:0]});
    end
    for (int t = 0; t < 2; t++) begin
      mact[t] = cs_ok[t] && fm[t] >= 0 && fm[t] < g[t];
      chk(redir_vld_o[t] == mact[t], sq[t] ? "R7" : "R6", $sformatf("redir_vld t%0d", t),
          64'(redir_vld_o[t]), 64'(mact[t]));
      if (mact[t])
        chk(redir_pc_o[t*32 +: 32] == str[t][fm[t]].tgt, "R6", $sformatf("redir_pc t%0d", t),
            64'(redir_pc_o[t*32 +: 32]), 64'(str[t][fm[t]].tgt));
      chk(blk_o[t] == eblk[t], "R2", $sformatf("blk t%0d", t), 64'(blk_o[t]), 64'(eblk[t]));
      chk(unblk_o[t] == eunb[t], "R4", $sformatf("unblk t%0d", t), 64'(unblk_o[t]), 64'(eunb[t]));
    end
    begin
      bit ea;
      ea = (fv != 0) || skid[0].size() != 0 || skid[1].size() != 0 ||
           st[0] != S_IDLE || st[1] != S_IDLE;
      chk(active_o == ea, "R9", "active", 64'(active_o), 64'(ea));
    end
    for (int t = 0; t < 2; t++) begin
      ns = st[t];
      if (sq[t]) begin ns = S_SQ; skid[t].delete(); end
      else if (st[t] == S_SSQ || st[t] == S_SQ) begin
        ns = stl[t] ? S_BLK : S_IDLE; skid[t].delete();
      end else if (stl[t] || st[t] == S_BLK) begin
        ns = stl[t] ? S_BLK : S_UNB;
        skid[t].delete();
        foreach (str[t][i]) if (i < DEPTH) skid[t].push_back(str[t][i]);
      end else if (mact[t]) begin
        ns = S_SSQ; skid[t].delete();
      end else begin
        skid[t].delete();
        foreach (str[t][i]) if (i >= g[t] && skid[t].size() < DEPTH) skid[t].push_back(str[t][i]);
        if (skid[t].size() > 0) ns = S_UNB;
        else if (st[t] == S_UNB) ns = S_RUN;
        else ns = (g[t] > 0) ? S_RUN : S_IDLE;
      end
      eblk[t] = (ns == S_BLK) && (st[t] != S_BLK);
      eunb[t] = (st[t] == S_UNB) && (ns == S_RUN);
      st[t] = ns;
    end
    rr = 1 - rr;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    st[0] = S_IDLE; st[1] = S_IDLE;
    stall_left[0] = 0; stall_left[1] = 0;
    eblk[0] = 0; eblk[1] = 0; eunb[0] = 0; eunb[1] = 0;
    repeat (3) @(negedge clk_i);
    #2;
    // R10: reset state
    chk(out_vld_o == '0, "R10", "out_vld in reset", 64'(out_vld_o), 0);
    chk(redir_vld_o == '0 && blk_o == '0 && unblk_o == '0, "R10", "pulses in reset",
        {58'b0, redir_vld_o, blk_o, unblk_o}, 0);
    chk(active_o == 1'b0, "R10", "active in reset", 64'(active_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      if (c > 0) @(negedge clk_i);
      drive(c < 300 ? 0 : (c < 1500 ? 1 : 2));
      #2;
      model_check();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule